// File: doc/BRIEF.md
# PWM Shadow Register Commit Unit

This block sits between a software register write port and a PWM generator. It keeps a staging copy of four duty-cycle values and one period value, plus the live copy that the time base and comparators read. Software writes only the staging copies. The block decides when those copies move into the live copies. A single-cycle strobe from the time base marks each period boundary.

Normally each staged write goes live at the next period boundary. Software can also set a lockout bit. While the bit is set, boundaries move nothing. Software then writes as many staged values as it needs. Clearing the bit commits all five staged values in one clock, so the PWM never runs with a mix of old and new settings. A one-cycle pulse on `updated_o` marks every cycle in which the live values were reloaded.

Top module: `pwm_shadow_commit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, all four duty outputs, `period_o` and `updated_o` read zero, and the lockout bit is clear.
- R2: A write with `wr_en` high selects its target by `wr_addr`: 0 to 3 write duty channel 0 to 3 from `wr_data[13:0]` (channel n occupies `duty_o[14n+13:14n]`), 4 writes the period from `wr_data[11:0]`, and 5 writes the lockout bit from `wr_data[0]`. A write never changes the outputs in the cycle right after it unless a transfer happens at that edge.
- R3: With the lockout bit clear, a clock edge at which `boundary_i` is high and at least one staged write has not yet gone live copies all five staged values to the outputs. The new values appear in the cycle after that edge.
- R4: While the lockout bit is set, `boundary_i` causes no transfer and the outputs hold their values.
- R5: A write of 0 to the lockout bit while it is set copies all five staged values to the outputs at that edge, whether or not `boundary_i` is high.
- R6: A staged write at the same edge as a boundary transfer keeps its new value in the staging copy and is not lost. That edge transfers the earlier staged values, and the new value goes live at the next transfer.
- R7: `updated_o` is high for exactly the cycles that follow a transfer edge, and the outputs change only in such cycles. A boundary with nothing staged causes no transfer.
- R8: Writes to addresses 6 and 7 have no effect.
- R9: Writing 0 to the lockout bit while it is already clear does not cause a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| boundary_i | input | 1 | Period-boundary strobe from the time base |
| duty_o | output | 56 | Live duty values, channel n in bits [14n+13:14n] |
| period_o | output | 12 | Live period value |
| updated_o | output | 1 | One-cycle pulse after each transfer |

## Verification
The hardest case to reach from the ports is a staged write that lands on the exact edge of a boundary transfer. To be correct, the earlier staged values must go live and the fresh value must stay pending until the next transfer. The stimulus forces this case on purpose: it stages a value, then repeats a write on the same cycle as the strobe. A long random phase follows. It mixes locked and unlocked periods, redundant lockout writes and dead addresses, with a strobe density high enough that the timing collisions happen many times.

// File: rtl/pwm_shd_pkg.sv
package pwm_shd_pkg;
    localparam int N_DUTY    = 4;
    localparam int DUTY_W    = 14;
    localparam int PER_W     = 12;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 3;
    localparam int PER_ADDR  = N_DUTY;
    localparam int CTRL_ADDR = N_DUTY + 1;

    typedef logic [DUTY_W-1:0] duty_t;
    typedef logic [PER_W-1:0]  per_t;

    typedef struct packed {
        per_t                    period;
        duty_t [N_DUTY-1:0]      duty;
    } pwm_set_t;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_BUF,
        WR_CTRL
    } wr_kind_e;

    function automatic wr_kind_e classify(input logic en, input logic [ADDR_W-1:0] a);
        if (!en)                          return WR_NONE;
        if (int'(a) <= PER_ADDR)          return WR_BUF;
        if (int'(a) == CTRL_ADDR)         return WR_CTRL;
        return WR_NONE;
    endfunction
endpackage

// File: rtl/pwm_shd_regfile.sv
module pwm_shd_regfile
    import pwm_shd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output pwm_set_t          stage,
    output logic              stage_wr,
    output logic              lock_q,
    output logic              unlock
);
    wr_kind_e kind;

    always_comb begin
        kind     = classify(wr_en, wr_addr);
        stage_wr = (kind == WR_BUF);
        unlock   = (kind == WR_CTRL) && lock_q && !wr_data[0];
    end

    for (genvar ch = 0; ch < N_DUTY; ch++) begin : g_duty
        always_ff @(posedge clk) begin
            if (rst)
                stage.duty[ch] <= '0;
            else if (kind == WR_BUF && int'(wr_addr) == ch)
                stage.duty[ch] <= wr_data[DUTY_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage.period <= '0;
            lock_q       <= 1'b0;
        end else begin
            if (kind == WR_BUF && int'(wr_addr) == PER_ADDR)
                stage.period <= wr_data[PER_W-1:0];
            if (kind == WR_CTRL)
                lock_q <= wr_data[0];
        end
    end
endmodule

// File: rtl/pwm_shd_commit.sv
module pwm_shd_commit (
    input  logic clk,
    input  logic rst,
    input  logic stage_wr,
    input  logic boundary,
    input  logic lock_q,
    input  logic unlock,
    output logic xfer,
    output logic pend_q
);
    always_comb xfer = unlock || (boundary && !lock_q && pend_q);

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (stage_wr)
            pend_q <= 1'b1;
        else if (xfer)
            pend_q <= 1'b0;
    end

    // R6
    keep_pending_chk: assert property (@(posedge clk) disable iff (rst)
        stage_wr |=> pend_q);

    // R4
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !unlock) |-> !xfer);
endmodule

// File: rtl/pwm_shd_active.sv
module pwm_shd_active
    import pwm_shd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     xfer,
    input  logic     unlock,
    input  pwm_set_t stage,
    output pwm_set_t live,
    output logic     updated_q
);
    for (genvar ch = 0; ch < N_DUTY; ch++) begin : g_live
        always_ff @(posedge clk) begin
            if (rst)       live.duty[ch] <= '0;
            else if (xfer) live.duty[ch] <= stage.duty[ch];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live.period <= '0;
            updated_q   <= 1'b0;
        end else begin
            if (xfer) live.period <= stage.period;
            updated_q <= xfer;
        end
    end

    // R7
    quiet_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !updated_q |-> $stable(live));

    // R5
    unlock_commit_chk: assert property (@(posedge clk) disable iff (rst)
        unlock |=> (updated_q && live == $past(stage)));
endmodule

// File: rtl/pwm_shadow_commit.sv
module pwm_shadow_commit
    import pwm_shd_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     boundary_i,
    output logic [N_DUTY*DUTY_W-1:0] duty_o,
    output logic [PER_W-1:0]         period_o,
    output logic                     updated_o
);
    pwm_set_t stage, live;
    logic     stage_wr, lock_q, unlock, xfer, pend_q;

    pwm_shd_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .stage(stage), .stage_wr(stage_wr), .lock_q(lock_q), .unlock(unlock)
    );

    pwm_shd_commit u_commit (
        .clk(clk), .rst(rst), .stage_wr(stage_wr), .boundary(boundary_i),
        .lock_q(lock_q), .unlock(unlock), .xfer(xfer), .pend_q(pend_q)
    );

    pwm_shd_active u_live (
        .clk(clk), .rst(rst), .xfer(xfer), .unlock(unlock), .stage(stage),
        .live(live), .updated_q(updated_o)
    );

    for (genvar ch = 0; ch < N_DUTY; ch++) begin : g_out
        assign duty_o[ch*DUTY_W +: DUTY_W] = live.duty[ch];
    end
    assign period_o = live.period;
endmodule

// File: tb/sim_pwm_shadow_commit.sv
module sim_pwm_shadow_commit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        boundary_i = 1'b0;
    logic [55:0] duty_o;
    logic [11:0] period_o;
    logic        updated_o;

    int vectors = 0;
    int errors  = 0;
    string cur_req = "R1";

    int m_stage [5];
    int m_live  [5];
    bit m_lock, m_pend, m_upd;

    always #5 clk = ~clk;

    pwm_shadow_commit u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .boundary_i(boundary_i), .duty_o(duty_o), .period_o(period_o), .updated_o(updated_o)
    );

    task automatic model_reset();
        for (int i = 0; i < 5; i++) begin m_stage[i] = 0; m_live[i] = 0; end
        m_lock = 0; m_pend = 0; m_upd = 0;
    endtask

    task automatic compare();
        for (int i = 0; i < 4; i++) begin
            vectors++;
            if (int'(duty_o[i*14 +: 14]) != m_live[i]) begin
                errors++;
                $display("FAIL %s duty%0d got %0d expected %0d", cur_req, i, duty_o[i*14 +: 14], m_live[i]);
            end
        end
        vectors++;
        if (int'(period_o) != m_live[4]) begin
            errors++;
            $display("FAIL %s period got %0d expected %0d", cur_req, period_o, m_live[4]);
        end
        vectors++;
        if (updated_o != m_upd) begin
            errors++;
            $display("FAIL %s updated got %0b expected %0b", cur_req, updated_o, m_upd);
        end
    endtask

    task automatic step(input bit we, input int a, input int d, input bit bnd);
        bit unl, tx, bw;
        @(negedge clk);
        wr_en = we; wr_addr = 3'(a); wr_data = 16'(d); boundary_i = bnd;
        @(posedge clk);
        bw  = we && a <= 4;
        unl = we && a == 5 && m_lock && !d[0];
        tx  = unl || (bnd && !m_lock && m_pend);
        if (tx) for (int i = 0; i < 5; i++) m_live[i] = m_stage[i];
        m_upd = tx;
        if (bw) m_stage[a] = (a == 4) ? (d & 16'h0FFF) : (d & 16'h3FFF);
        if (bw) m_pend = 1; else if (tx) m_pend = 0;
        if (we && a == 5) m_lock = d[0];
        #1 compare();
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 compare();
        @(negedge clk); rst = 1'b0;
        cur_req = "R1"; step(0, 0, 0, 0);

        cur_req = "R2"; step(1, 0, 16'hFFFF, 0); step(1, 4, 16'hABCD, 0); step(1, 2, 100, 0);
        cur_req = "R3"; step(0, 0, 0, 1); step(0, 0, 0, 0);
        cur_req = "R7"; step(0, 0, 0, 1); step(0, 0, 0, 1);

        cur_req = "R4"; step(1, 5, 1, 0);
        for (int i = 0; i < 5; i++) step(1, i, 500 + i, 1);
        step(0, 0, 0, 1); step(1, 5, 1, 1);
        cur_req = "R5"; step(1, 5, 0, 0); step(0, 0, 0, 0);
        cur_req = "R9"; step(1, 5, 0, 0); step(1, 1, 7, 0); step(1, 5, 0, 0);

        cur_req = "R6"; step(1, 3, 77, 1); step(0, 0, 0, 0); step(0, 0, 0, 1); step(0, 0, 0, 0);
        step(1, 1, 11, 0); step(1, 1, 22, 1); step(0, 0, 0, 1); step(0, 0, 0, 1);

        cur_req = "R8"; step(1, 6, 999, 0); step(1, 7, 1, 1); step(0, 0, 0, 1);

        cur_req = "R3";
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom_range(0, 9));
            int a = (r < 6) ? int'($urandom_range(0, 4)) : int'($urandom_range(5, 7));
            step(r < 8, a, int'($urandom_range(0, 65535)), $urandom_range(0, 2) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule